// File: doc/BRIEF.md
# Mirrored Interprocessor-Message Register

This block holds one bus interface unit's copy of a register used to post interprocessor messages. The register exists twice in the system, once behind a primary memory bus and once behind a back-up memory bus. Every write reaches both copies as a memory-bus transaction, so the two copies always hold the same value. On the processor side, only one copy answers a read. The other copy completes the same transaction without driving data.

A static configuration input tells the unit which bus it sits on. A role bit starts in the normal setting after reset. In that setting the primary-bus copy answers and the back-up copy stays silent. An interchange pulse toggles the role bit, so the back-up path can be exercised on its own. The answering rule is: a unit on the primary bus answers while its primary range is enabled (role bit clear), and a unit on the back-up bus answers while its back-up range is enabled (role bit set).

A write is accepted into a pending slot and takes a fixed number of cycles to commit. While a write is pending, or while a write is offered in the same cycle, reads are held off by a ready signal. A read that follows a write therefore always returns the written value. Writes are taken one at a time, in arrival order.

Top module: `ipc_mirror_reg`

## Requirements
- R1: After reset the stored value is 0, the role bit is clear, no write is pending, `wr_ready` and `rd_ready` are 1, and `rsp_valid`, `rsp_drive` and `rsp_data` are 0.
- R2: A write accepted at a clock edge (`wr_valid` and `wr_ready` both high) commits its data to the stored value exactly `COMMIT_LAT` edges later. It does so whether or not this unit answers reads.
- R3: After a write is accepted, `wr_ready` is 0 for exactly `COMMIT_LAT` cycles. A second write waits and is applied after the first.
- R4: `rd_ready` is 0 whenever a write is pending or `wr_valid` is high in the same cycle.
- R5: A read accepted at an edge (`rd_valid` and `rd_ready` both high) gives a one-cycle `rsp_valid` pulse after that edge. If this unit answers, `rsp_drive` is 1 and `rsp_data` is the stored value.
- R6: When this unit does not answer, its accepted read still pulses `rsp_valid`, but `rsp_drive` is 0 and `rsp_data` is 0. Outside a response pulse, `rsp_drive` and `rsp_data` are 0.
- R7: The unit answers when `on_backup`=0 and the role bit is 0, or when `on_backup`=1 and the role bit is 1. Otherwise it stays silent.
- R8: Each clock edge with `xchg` high toggles the role bit.
- R9: A read issued behind a write (stalled, or offered together with it) returns the post-write value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| on_backup | input | 1 | 0: unit sits on the primary bus, 1: on the back-up bus |
| xchg | input | 1 | Interchange pulse, toggles the role bit |
| wr_valid | input | 1 | Memory-bus write offered |
| wr_data | input | WIDTH | Write data |
| wr_ready | output | 1 | Write slot free |
| rd_valid | input | 1 | Processor read offered |
| rd_ready | output | 1 | Read may complete this cycle |
| rsp_valid | output | 1 | Read completion pulse |
| rsp_drive | output | 1 | This unit drives read data |
| rsp_data | output | WIDTH | Read data, 0 when not driving |

## Verification
The bench offers a read in the cycle right after a write and in the same cycle as a write. A design that let either read through early would return the old value. The bench counts the cycles `wr_ready` stays low, which exposes a commit counter that is off by one. Random sequences on both bus sides mix interchanges, writes and reads. Two kinds of error would show up there: a silent copy that skipped writes would return stale data after the next interchange, and a swapped answer rule would drive data from the wrong bus.

// File: rtl/ipc_mirror_pkg.sv
package ipc_mirror_pkg;
   // Decide whether a unit answers processor reads for its bus side and role
   function automatic logic unit_answers(logic on_backup, logic swapped);
      return on_backup ? swapped : !swapped;
   endfunction
endpackage

// File: rtl/ipc_wr_commit.sv
module ipc_wr_commit #(
   parameter int WIDTH      = 16,
   parameter int COMMIT_LAT = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_valid,
   input  logic [WIDTH-1:0] wr_data,
   output logic             pending,
   output logic             commit,
   output logic [WIDTH-1:0] commit_data
);
   logic accept;
   assign accept = wr_valid && !pending;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pending     <= 1'b0;
         commit_data <= '0;
      end else if (accept) begin
         pending     <= 1'b1;
         commit_data <= wr_data;
      end else if (commit) begin
         pending     <= 1'b0;
      end
   end

   generate
      if (COMMIT_LAT == 1) begin : g_single
         assign commit = pending;
      end else begin : g_count
         localparam int CW = $clog2(COMMIT_LAT);
         logic [CW-1:0] remain;
         always_ff @(posedge clk) begin
            if (!rst_n)
               remain <= '0;
            else if (accept)
               remain <= CW'(COMMIT_LAT - 1);
            else if (pending && remain != '0)
               remain <= remain - 1'b1;
         end
         assign commit = pending && (remain == '0);
      end
   endgenerate
endmodule

// File: rtl/ipc_role_ctl.sv
module ipc_role_ctl (
   input  logic clk,
   input  logic rst_n,
   input  logic xchg,
   input  logic on_backup,
   output logic swapped,
   output logic answer
);
   always_ff @(posedge clk) begin
      if (!rst_n)
         swapped <= 1'b0;
      else if (xchg)
         swapped <= !swapped;
   end

   assign answer = ipc_mirror_pkg::unit_answers(on_backup, swapped);
endmodule

// File: rtl/ipc_rd_port.sv
module ipc_rd_port #(
   parameter int WIDTH = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rd_fire,
   input  logic             answer,
   input  logic [WIDTH-1:0] value,
   output logic             rsp_valid,
   output logic             rsp_drive,
   output logic [WIDTH-1:0] rsp_data
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_drive <= 1'b0;
         rsp_data  <= '0;
      end else begin
         rsp_valid <= rd_fire;
         rsp_drive <= rd_fire && answer;
         rsp_data  <= (rd_fire && answer) ? value : '0;
      end
   end
endmodule

// File: rtl/ipc_mirror_reg.sv
module ipc_mirror_reg #(
   parameter int WIDTH      = 16,
   parameter int COMMIT_LAT = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             on_backup,
   input  logic             xchg,
   input  logic             wr_valid,
   input  logic [WIDTH-1:0] wr_data,
   output logic             wr_ready,
   input  logic             rd_valid,
   output logic             rd_ready,
   output logic             rsp_valid,
   output logic             rsp_drive,
   output logic [WIDTH-1:0] rsp_data
);
   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("ipc_mirror_reg: WIDTH must be at least 1");
      end
      if (COMMIT_LAT < 1) begin : g_bad_lat
         $error("ipc_mirror_reg: COMMIT_LAT must be at least 1");
      end
   endgenerate

   logic             pending;
   logic             commit;
   logic [WIDTH-1:0] commit_data;
   logic [WIDTH-1:0] value_q;
   logic             swapped;
   logic             answer;
   logic             rd_fire;

   ipc_wr_commit #(.WIDTH(WIDTH), .COMMIT_LAT(COMMIT_LAT)) u_wr (
      .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
      .pending(pending), .commit(commit), .commit_data(commit_data)
   );

   // Every committed write lands here, whatever the answering role
   always_ff @(posedge clk) begin
      if (!rst_n)
         value_q <= '0;
      else if (commit)
         value_q <= commit_data;
   end

   ipc_role_ctl u_role (
      .clk(clk), .rst_n(rst_n), .xchg(xchg), .on_backup(on_backup),
      .swapped(swapped), .answer(answer)
   );

   // A write offered in the same cycle is ordered ahead of the read
   assign wr_ready = !pending;
   assign rd_ready = !pending && !wr_valid;
   assign rd_fire  = rd_valid && rd_ready;

   ipc_rd_port #(.WIDTH(WIDTH)) u_rd (
      .clk(clk), .rst_n(rst_n), .rd_fire(rd_fire), .answer(answer),
      .value(value_q), .rsp_valid(rsp_valid), .rsp_drive(rsp_drive),
      .rsp_data(rsp_data)
   );
endmodule

// File: rtl/ipc_mirror_chk.sv
module ipc_mirror_chk #(
   parameter int WIDTH = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             on_backup,
   input logic             xchg,
   input logic             wr_valid,
   input logic             wr_ready,
   input logic             rd_valid,
   input logic             rd_ready,
   input logic             rsp_valid,
   input logic             rsp_drive,
   input logic [WIDTH-1:0] rsp_data,
   input logic             swapped
);
   // R6: silent outputs are zero
   p_silent_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !rsp_drive |-> rsp_data == '0);
   p_idle_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !rsp_valid |-> !rsp_drive);
   // R4: reads held while the write slot is busy or a write is offered
   p_rd_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_ready || wr_valid) |-> !rd_ready);
   // R3: an accepted write occupies the slot
   p_wr_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && wr_ready) |=> !wr_ready);
   // R5: response pulse follows each accepted read and nothing else
   p_rsp_follow_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && rd_ready) |=> rsp_valid);
   p_rsp_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_valid && rd_ready) |=> !rsp_valid);
   // R8: interchange toggles the role
   p_xchg_r8: assert property (@(posedge clk) disable iff (!rst_n)
      xchg |=> swapped != $past(swapped));
   // R7: drive follows bus side and role at acceptance
   p_role_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && rd_ready) |=> rsp_drive == $past(on_backup == swapped));
endmodule

bind ipc_mirror_reg ipc_mirror_chk #(.WIDTH(WIDTH)) u_chk (
   .clk(clk), .rst_n(rst_n), .on_backup(on_backup), .xchg(xchg),
   .wr_valid(wr_valid), .wr_ready(wr_ready), .rd_valid(rd_valid),
   .rd_ready(rd_ready), .rsp_valid(rsp_valid), .rsp_drive(rsp_drive),
   .rsp_data(rsp_data), .swapped(swapped)
);

// File: tb/ipc_mirror_reg_tb.sv
module ipc_mirror_reg_tb;
   localparam int WIDTH = 16;
   localparam int LAT   = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic on_backup = 1'b0;
   logic xchg = 1'b0;
   logic wr_valid = 1'b0;
   logic [WIDTH-1:0] wr_data = '0;
   logic wr_ready, rd_ready, rsp_valid, rsp_drive;
   logic rd_valid = 1'b0;
   logic [WIDTH-1:0] rsp_data;

   int tests = 0;
   int fails = 0;
   logic [WIDTH-1:0] m_val;
   logic m_swap;
   int seed_dummy;

   always #5 clk = !clk;

   ipc_mirror_reg #(.WIDTH(WIDTH), .COMMIT_LAT(LAT)) u_dut (
      .clk(clk), .rst_n(rst_n), .on_backup(on_backup), .xchg(xchg),
      .wr_valid(wr_valid), .wr_data(wr_data), .wr_ready(wr_ready),
      .rd_valid(rd_valid), .rd_ready(rd_ready), .rsp_valid(rsp_valid),
      .rsp_drive(rsp_drive), .rsp_data(rsp_data)
   );

   function automatic logic exp_answer(logic side, logic sw);
      return side ? sw : !sw;
   endfunction

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic do_reset(logic side);
      @(negedge clk);
      rst_n = 1'b0; on_backup = side; wr_valid = 1'b0; rd_valid = 1'b0; xchg = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      m_val = '0; m_swap = 1'b0;
   endtask

   task automatic do_xchg();
      @(negedge clk);
      xchg = 1'b1;
      @(negedge clk);
      xchg = 1'b0;
      m_swap = !m_swap;
   endtask

   // Write, then count the cycles the slot stays busy (R2, R3)
   task automatic do_write(logic [WIDTH-1:0] d);
      int busy;
      @(negedge clk);
      while (!wr_ready) @(negedge clk);
      wr_valid = 1'b1; wr_data = d;
      @(negedge clk);
      wr_valid = 1'b0;
      busy = 0;
      while (!wr_ready) begin busy++; @(negedge clk); end
      check("R3 busy cycles", busy, LAT);
      m_val = d;
   endtask

   task automatic do_read(string req);
      @(negedge clk);
      rd_valid = 1'b1;
      #1;
      while (!rd_ready) begin @(negedge clk); #1; end
      @(negedge clk);
      rd_valid = 1'b0;
      #1;
      check({req, " R5 valid"}, rsp_valid, 1);
      check({req, " R7 drive"}, rsp_drive, exp_answer(on_backup, m_swap));
      check({req, " R6 data"}, rsp_data,
            exp_answer(on_backup, m_swap) ? m_val : '0);
      @(negedge clk);
      #1;
      check("R5 one-cycle pulse", rsp_valid, 0);
   endtask

   initial begin
      #2_000_000;
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      seed_dummy = $urandom(32'h1A2B);
      do_reset(1'b0);
      #1;
      check("R1 wr_ready", wr_ready, 1);
      check("R1 rd_ready", rd_ready, 1);
      check("R1 rsp", {rsp_valid, rsp_drive, rsp_data}, 0);
      do_read("R1 reset value");

      // R9: read stalled behind a pending write
      @(negedge clk);
      wr_valid = 1'b1; wr_data = 16'hBEEF;
      @(negedge clk);
      wr_valid = 1'b0; rd_valid = 1'b1;
      #1;
      check("R4 stall while pending", rd_ready, 0);
      while (!rd_ready) begin @(negedge clk); #1; end
      @(negedge clk);
      rd_valid = 1'b0;
      #1;
      check("R9 post-write value", rsp_data, 16'hBEEF);
      m_val = 16'hBEEF;

      // R9: read offered together with a write
      @(negedge clk);
      wr_valid = 1'b1; wr_data = 16'h1234; rd_valid = 1'b1;
      #1;
      check("R4 stall with write offered", rd_ready, 0);
      @(negedge clk);
      wr_valid = 1'b0;
      #1;
      while (!rd_ready) begin @(negedge clk); #1; end
      @(negedge clk);
      rd_valid = 1'b0;
      #1;
      check("R9 same-cycle write first", rsp_data, 16'h1234);
      m_val = 16'h1234;

      // R2: silent copy still applies writes, seen after interchange (R8)
      do_xchg();
      do_read("R6 primary silent");
      do_write(16'h0F0F);
      do_xchg();
      do_read("R2 write applied while silent");

      // Back-up side, then random mix on both sides
      for (int side = 0; side < 2; side++) begin
         do_reset(side[0]);
         do_read("R7 normal role");
         do_xchg();
         do_read("R8 after interchange");
         for (int i = 0; i < 120; i++) begin
            case ($urandom_range(0, 2))
               0: do_write(WIDTH'($urandom));
               1: do_xchg();
               default: do_read("R5 random read");
            endcase
         end
      end

      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule